// File: doc/BRIEF.md
# Trace Qualifier Signal Generator

This block decides, frame by frame, whether a debug trace port should keep the link frame it is seeing. It takes a frame-valid pulse, a flag that marks sync frames, start and stop event pulses from external match logic, and a status bit that is high once the link has reached its L0 state. It produces a qualify strobe for each frame, and a select line that steers the trace data mux to either initialization-state information or live lane data.

Three controls shape the qualify strobe. A window mode limits qualification to the frames between a start event and a stop event. A sync filter drops sync frames. A hold period keeps the strobe high for a programmed number of extra valid frames after the last frame that qualified on its own merits. A raw-mode control forces the mux to lane data even before the link reaches L0. The controls live in a small register with two write strobes that share one data bus: one strobe writes the three mode bits and the other writes the hold period.

Both outputs are registered. They refer to the frame presented on the cycle before, which matches the one-stage register on the trace data path.

Top module: `tq_qual_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `qual_o` and `sel_lane_o` are 0. After reset the raw, window-mode and sync-filter controls are 0.
- R2: With window mode 0, start and stop events have no effect, and every valid frame that the sync filter does not drop is qualified.
- R3: With window mode 1, a frame is qualified only inside the window. A frame that carries a start event opens the window and is itself qualified. A frame that carries a stop event closes the window and is not qualified. Frames with no event follow the state left by the last event.
- R4: When start and stop are both high in the same cycle, stop wins: the window is closed, and that frame and later frames stay unqualified until the next start.
- R5: With the sync filter on, a valid frame with `frm_sync_i`=1 does not qualify on its own merits. With the filter off, sync frames are treated like any other frame.
- R6: Every frame that qualifies on its own merits reloads a hold counter with the period P. Each later valid frame that does not qualify on its own merits is still qualified while the counter is non-zero, and it decrements the counter. So exactly P extra valid frames are qualified, and cycles without a valid frame do not use up the hold.
- R7: After reset the hold period is 63. With the filter on, one non-sync frame followed by sync frames qualifies that frame and the next 63 frames, but not the 64th.
- R8: While window mode is 0 the window is held closed. Turning window mode off and on again leaves the window closed until a new start event.
- R9: `sel_lane_o` is 1 (lane data) when raw mode is 1, or when `link_l0_i` was 1 on the previous cycle. Otherwise it is 0 (initialization-state data).
- R10: `qual_o` is registered. It can be 1 only in the cycle after a cycle with `frm_vld_i`=1, and it describes that frame.
- R11: When `cfg_wr_ctl_i` is pulsed, `cfg_wdata_i` bit 0 sets the sync filter, bit 1 sets window mode and bit 2 sets raw mode. When `cfg_wr_hold_i` is pulsed, `cfg_wdata_i[HOLD_W-1:0]` sets the hold period. The new values apply from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_ctl_i | input | 1 | Writes the mode bits from cfg_wdata_i[2:0] |
| cfg_wr_hold_i | input | 1 | Writes the hold period from cfg_wdata_i |
| cfg_wdata_i | input | HOLD_W | Configuration write data |
| frm_vld_i | input | 1 | One-cycle pulse per received frame |
| frm_sync_i | input | 1 | The current frame is a sync frame |
| evt_start_i | input | 1 | Start event for the qualify window |
| evt_stop_i | input | 1 | Stop event for the qualify window |
| link_l0_i | input | 1 | The link has reached L0 |
| qual_o | output | 1 | Registered qualify strobe for the previous cycle's frame |
| sel_lane_o | output | 1 | Registered trace mux select: 1 lane data, 0 init-state data |

## Verification
The assertions check on every cycle that:
- a qualify strobe only ever follows a valid frame;
- stop beats a simultaneous start;
- the window stays shut while window mode is off;
- the hold counter reloads to the period and then counts down by one per unqualified frame;
- filtered sync frames and frames outside the window do not qualify when no hold is pending;
- raw mode forces lane data.

Only the bench's scenarios can show the end-to-end frame counts. These are the exact extra frames given by a period (including the 63 after reset), reloads in the middle of a hold, a window that stays closed after the mode is switched off and on again, and the mixed long-run behaviour under random events, sync flags and configuration writes.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic {
    TQ_SEL_INIT = 1'b0,
    TQ_SEL_LANE = 1'b1
  } tq_sel_e;

  localparam int TQ_CTL_SYNC_BIT = 0;
  localparam int TQ_CTL_WIN_BIT  = 1;
  localparam int TQ_CTL_RAW_BIT  = 2;
endpackage

// File: rtl/tq_cfg.sv
module tq_cfg #(
  parameter int HOLD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_hold,
  input  logic [HOLD_W-1:0] wdata,
  output logic              raw,
  output logic              win_en,
  output logic              sync_drop,
  output logic [HOLD_W-1:0] hold
);
  import tq_pkg::*;
  localparam logic [HOLD_W-1:0] HOLD_RST = {HOLD_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      raw       <= 1'b0;
      win_en    <= 1'b0;
      sync_drop <= 1'b0;
      hold      <= HOLD_RST;
    end else begin
      if (wr_ctl) begin
        sync_drop <= wdata[TQ_CTL_SYNC_BIT];
        win_en    <= wdata[TQ_CTL_WIN_BIT];
        raw       <= wdata[TQ_CTL_RAW_BIT];
      end
      if (wr_hold) hold <= wdata;
    end
  end
endmodule

// File: rtl/tq_window.sv
module tq_window (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic start,
  input  logic stop,
  output logic win_eff,
  output logic win_q
);
  logic win_nxt;

  always_comb begin
    if (stop)       win_nxt = 1'b0;
    else if (start) win_nxt = 1'b1;
    else            win_nxt = win_q;
    win_eff = mode & win_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= win_eff;
  end

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
    (start && stop) |=> !win_q); // R4
  AST_MODE_OFF_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !mode |=> !win_q); // R8
endmodule

// File: rtl/tq_hold.sv
module tq_hold #(
  parameter int HOLD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              elig,
  input  logic              frm_vld,
  input  logic [HOLD_W-1:0] period,
  output logic              busy
);
  logic [HOLD_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (elig)          cnt <= period;
    else if (frm_vld && busy) cnt <= cnt - 1'b1;
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    elig |=> (cnt == $past(period))); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!elig && frm_vld && busy) |=> (cnt == $past(cnt) - 1'b1)); // R6
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!elig && !frm_vld) |=> $stable(cnt)); // R6
endmodule

// File: rtl/tq_qual_gen.sv
module tq_qual_gen #(
  parameter int HOLD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_ctl_i,
  input  logic              cfg_wr_hold_i,
  input  logic [HOLD_W-1:0] cfg_wdata_i,
  input  logic              frm_vld_i,
  input  logic              frm_sync_i,
  input  logic              evt_start_i,
  input  logic              evt_stop_i,
  input  logic              link_l0_i,
  output logic              qual_o,
  output logic              sel_lane_o
);
  import tq_pkg::*;

  logic              c_raw, c_win, c_sync;
  logic [HOLD_W-1:0] c_hold;
  logic              win_eff, win_q;
  logic              elig, hold_busy;
  tq_sel_e           sel_nxt;

  tq_cfg #(.HOLD_W(HOLD_W)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_ctl(cfg_wr_ctl_i), .wr_hold(cfg_wr_hold_i), .wdata(cfg_wdata_i),
    .raw(c_raw), .win_en(c_win), .sync_drop(c_sync), .hold(c_hold)
  );

  tq_window u_win (
    .clk(clk), .rst(rst), .mode(c_win),
    .start(evt_start_i), .stop(evt_stop_i),
    .win_eff(win_eff), .win_q(win_q)
  );

  always_comb begin
    elig    = frm_vld_i && !(c_sync && frm_sync_i) && (!c_win || win_eff);
    sel_nxt = (c_raw || link_l0_i) ? TQ_SEL_LANE : TQ_SEL_INIT;
  end

  tq_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .elig(elig), .frm_vld(frm_vld_i),
    .period(c_hold), .busy(hold_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_o     <= 1'b0;
      sel_lane_o <= 1'b0;
    end else begin
      qual_o     <= elig || (frm_vld_i && hold_busy);
      sel_lane_o <= (sel_nxt == TQ_SEL_LANE);
    end
  end

  AST_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> $past(frm_vld_i)); // R10
  AST_SYNC_DROP: assert property (@(posedge clk) disable iff (rst)
    (frm_vld_i && frm_sync_i && c_sync && !hold_busy) |=> !qual_o); // R5
  AST_WIN_GATE: assert property (@(posedge clk) disable iff (rst)
    (c_win && !win_eff && !hold_busy) |=> !qual_o); // R3
  AST_RAW_LANE: assert property (@(posedge clk) disable iff (rst)
    c_raw |=> sel_lane_o); // R9
endmodule

// File: tb/sim_tq_qual_gen.sv
module sim_tq_qual_gen;
  localparam int HW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_ctl = 1'b0, wr_hold = 1'b0;
  logic [HW-1:0] wdata = '0;
  logic          vld = 1'b0, sync = 1'b0, st = 1'b0, sp = 1'b0, l0 = 1'b0;
  logic          qual, sel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  bit m_raw, m_mode, m_sd, m_win;
  int m_hold, m_cnt;

  always #10 clk = ~clk;

  tq_qual_gen #(.HOLD_W(HW)) u0 (
    .clk(clk), .rst(rst),
    .cfg_wr_ctl_i(wr_ctl), .cfg_wr_hold_i(wr_hold), .cfg_wdata_i(wdata),
    .frm_vld_i(vld), .frm_sync_i(sync), .evt_start_i(st), .evt_stop_i(sp),
    .link_l0_i(l0), .qual_o(qual), .sel_lane_o(sel)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit win_next(input bit start, input bit stop, input bit cur);
    if (stop) return 1'b0;
    if (start) return 1'b1;
    return cur;
  endfunction

  // one cycle: drive at negedge, model, then compare at following negedge
  task automatic cyc(input bit f, input bit s, input bit a, input bit b, input bit l,
                     input bit wc, input bit wh, input logic [HW-1:0] wd, input string req);
    bit weff, elig, eq, es;
    vld = f; sync = s; st = a; sp = b; l0 = l;
    wr_ctl = wc; wr_hold = wh; wdata = wd;
    weff = m_mode && win_next(a, b, m_win);
    elig = f && !(m_sd && s) && (!m_mode || weff);
    eq   = elig || (f && m_cnt != 0);
    es   = m_raw || l;
    m_win = weff;
    if (elig) m_cnt = m_hold;
    else if (f && m_cnt != 0) m_cnt = m_cnt - 1;
    if (wc) begin m_sd = wd[0]; m_mode = wd[1]; m_raw = wd[2]; end
    if (wh) m_hold = int'(wd);
    @(posedge clk);
    @(negedge clk);
    chk(req, qual, eq, "qual_o");
    chk(req, sel, es, "sel_lane_o");
  endtask

  task automatic frame(input bit s, input bit a, input bit b, input string req);
    cyc(1'b1, s, a, b, 1'b0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic wctl(input bit sd, input bit md, input bit rw);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, HW'({rw, md, sd}), "R11");
  endtask

  task automatic whold(input int h);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, HW'(h), "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_raw = 0; m_mode = 0; m_sd = 0; m_win = 0; m_hold = 63; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1", qual, 1'b0, "qual_o in reset");
    chk("R1", sel, 1'b0, "sel_lane_o in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", qual, 1'b0, "qual_o after reset");
    chk("R1", sel, 1'b0, "sel_lane_o after reset");

    // R7: default hold of 63 frames
    wctl(1'b1, 1'b0, 1'b0);
    frame(1'b0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 64; i++) frame(1'b1, 1'b0, 1'b0, "R7");

    // R5: sync filter with no hold
    whold(0);
    frame(1'b1, 1'b0, 1'b0, "R5");
    frame(1'b0, 1'b0, 1'b0, "R5");
    wctl(1'b0, 1'b0, 1'b0);
    frame(1'b1, 1'b0, 1'b0, "R5");

    // R6: hold of 2 with reload and idle gaps
    wctl(1'b1, 1'b0, 1'b0);
    whold(2);
    frame(1'b0, 1'b0, 1'b0, "R6");
    frame(1'b1, 1'b0, 1'b0, "R6");
    idle("R6"); idle("R6");
    frame(1'b1, 1'b0, 1'b0, "R6");
    frame(1'b0, 1'b0, 1'b0, "R6");
    frame(1'b1, 1'b0, 1'b0, "R6");
    frame(1'b1, 1'b0, 1'b0, "R6");
    frame(1'b1, 1'b0, 1'b0, "R6");
    frame(1'b1, 1'b0, 1'b0, "R6");

    // R2: events ignored in mode 0
    whold(0);
    wctl(1'b0, 1'b0, 1'b0);
    frame(1'b0, 1'b0, 1'b1, "R2");
    frame(1'b0, 1'b0, 1'b0, "R2");
    frame(1'b0, 1'b1, 1'b0, "R2");

    // R3: window
    wctl(1'b0, 1'b1, 1'b0);
    frame(1'b0, 1'b0, 1'b0, "R3");
    frame(1'b0, 1'b1, 1'b0, "R3");
    frame(1'b0, 1'b0, 1'b0, "R3");
    idle("R3");
    frame(1'b0, 1'b0, 1'b0, "R3");
    frame(1'b0, 1'b0, 1'b1, "R3");
    frame(1'b0, 1'b0, 1'b0, "R3");

    // R4: simultaneous start and stop
    frame(1'b0, 1'b1, 1'b0, "R4");
    frame(1'b0, 1'b1, 1'b1, "R4");
    frame(1'b0, 1'b0, 1'b0, "R4");

    // R8: mode off and on closes window
    frame(1'b0, 1'b1, 1'b0, "R8");
    wctl(1'b0, 1'b0, 1'b0);
    wctl(1'b0, 1'b1, 1'b0);
    frame(1'b0, 1'b0, 1'b0, "R8");

    // R9: trace data select
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R9");
    wctl(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");
    wctl(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");

    // R10: random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 40);
      if (r == 0)
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'($urandom), 1'b1, 1'b0, HW'($urandom), "R10");
      else if (r == 1)
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'($urandom), 1'b0, 1'b1, HW'($urandom % 6), "R10");
      else
        cyc(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 9) == 0,
            ($urandom % 11) == 0, ($urandom % 5) != 0, 1'b0, 1'b0, '0, "R10");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule